// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transceiver

This block moves characters between a parallel host side and a pair of single-wire serial lines, one for each direction, both running at once. A fractional baud generator turns the fixed core clock into a tick at sixteen times the bit rate. The transmitter serialises a one-character holding buffer. The receiver detects a start edge, samples each bit at its middle and delivers the character to a one-character receive register.

The frame layout is chosen at run time and the same settings serve both directions. A frame is one low start bit, then 6 to 9 data bits in either order, then an optional parity bit (even or odd), then one or two high stop bits. The line rests high between frames. The host writes characters with a strobe and reads the received character with another strobe. A four-bit status word reports the flags: receive-ready, transmit-buffer-empty, parity error and framing error.

Both directions are built as state machines with the states IDLE, START, DATA, PARITY and STOP. The transmitter moves IDLE→START on a tick when its buffer is full. It moves START→DATA after 16 ticks. It moves DATA→PARITY (or DATA→STOP when parity is off) after the last data bit, and PARITY→STOP after 16 ticks. It leaves STOP after the last stop bit: STOP→START when another character is waiting, otherwise STOP→IDLE. The receiver moves IDLE→START on a tick that sees the line low. At the eighth tick it goes START→DATA, or START→IDLE when the line has gone high again. DATA→PARITY/STOP and PARITY→STOP happen at bit midpoints. STOP→IDLE happens at the midpoint of the last stop bit, and that is where the character is delivered.

Top module: `uart_xcvr`

## Requirements
- R1: While reset is asserted, `txd` is 1 and `status` is 4'b0010: only transmit-empty is set.
- R2: The baud tick period is `cfg_div_int` or `cfg_div_int`+1 clocks. Tick n after reset falls on clock n·div + floor(n·frac/16), so every 16 ticks take exactly 16·div + frac clocks. `cfg_div_int` must be at least 1.
- R3: `txd` sends a 0 start bit, then the data bits, then the parity bit if enabled, then the stop bits at 1: one stop bit when `cfg_stop2`=0, two when it is 1. Each bit lasts 16 ticks. A frame starts on the first tick after the buffer fills, and a waiting character follows the last stop bit with no gap.
- R4: `cfg_len` code 0,1,2,3 selects 6,7,8,9 data bits. Data is right-aligned in `tx_data` and `rx_data`. Unused upper bits are ignored on transmit and read as 0 on receive.
- R5: `cfg_msb_first`=0 sends and receives bit 0 first. `cfg_msb_first`=1 sends and receives bit len-1 first.
- R6: With `cfg_par_en`=1 the parity bit makes the count of ones over data and parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). The receiver applies the same rule.
- R7: `status[1]` is the transmit-empty flag. A `tx_wr` while it is 1 loads the buffer and clears it. A `tx_wr` while it is 0 is ignored. It sets again in the cycle the frame's start bit appears on `txd`.
- R8: The receiver samples the start bit 8 ticks after it sees the line low, and each later bit 16 ticks after the previous sample. Disturbances away from bit midpoints do not change the received data.
- R9: A low pulse that has ended by the start-bit midpoint returns the receiver to IDLE without delivering a character.
- R10: `status[0]` sets when a character is delivered to `rx_data` and clears on `rx_rd`. A delivery in the same cycle as `rx_rd` wins.
- R11: `status[2]` sets on a parity mismatch and `status[3]` sets on any stop bit sampled low. Both stay set until `err_clr`, and a setting event wins over a clear in the same cycle. The character is delivered either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div_int | input | DIV_W | Integer part of the tick divisor |
| cfg_div_frac | input | 4 | Fractional part of the divisor in sixteenths |
| cfg_len | input | 2 | Data length code (6 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | Most significant bit first when 1 |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 9 | Character to transmit |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Read strobe, clears receive-ready |
| err_clr | input | 1 | Clears the parity and framing error flags |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 9 | Last received character |
| status | output | 4 | {framing err, parity err, tx empty, rx ready} |

## Verification
The hardest case to reach from the ports is the tick pattern under a non-zero fraction. The extra clocks only show up as one-cycle shifts in `txd` edges, deep inside a frame. The bench models the tick schedule from the closed formula, models the line as a queue of bits, and compares `txd` and the empty flag on every clock for several divisor and fraction pairs. To exercise the receiver's midpoint sampling and glitch rejection, the bench drives frames whose data bits are inverted near their edges, low pulses shorter than half a bit, and a stop bit held low, which also leaves the line low just after the receiver returns to IDLE.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } frame_st_t;

    localparam int WORD_W = 9;
    localparam int STAT_W = 4;
    localparam int TICKS_PER_BIT = 16;
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] MID_TICK = CNT_W'(TICKS_PER_BIT / 2 - 1);

    function automatic logic [3:0] frame_len(input logic [1:0] code);
        return 4'd6 + {2'b00, code};
    endfunction

    function automatic logic [WORD_W-1:0] len_mask(input logic [3:0] n);
        return {WORD_W{1'b1}} >> (4'(WORD_W) - n);
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_int,
    input  logic [3:0]       div_frac,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [3:0]       acc;
    logic [4:0]       acc_sum;

    assign acc_sum = {1'b0, acc} + {1'b0, div_frac};
    assign tick    = (cnt == '0);

    // The sixteenths accumulator carries frac times per 16 ticks, lengthening those periods by one clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (tick) begin
            cnt <= div_int - DIV_W'(1) + DIV_W'(acc_sum[4]);
            acc <= acc_sum[3:0];
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              msb_first,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              txd,
    output logic              buf_empty
);
    frame_st_t         st, st_n;
    logic [CNT_W-1:0]  tcnt;
    logic [3:0]        bidx, nbits, last_idx, sel;
    logic [WORD_W-1:0] hold_q, shf;
    logic              hold_full, bit_end, stop_last, load, par_bit;

    assign nbits     = frame_len(len_code);
    assign last_idx  = nbits - 4'd1;
    assign bit_end   = tick && (tcnt == LAST_TICK);
    assign stop_last = !stop2 || (bidx == 4'd1);
    assign load      = (st_n == ST_START) && (st != ST_START);
    assign sel       = msb_first ? (last_idx - bidx) : bidx;
    assign par_bit   = (^(shf & len_mask(nbits))) ^ par_odd;
    assign buf_empty = !hold_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (tick && hold_full) st_n = ST_START;
            ST_START: if (bit_end) st_n = ST_DATA;
            ST_DATA:  if (bit_end && (bidx == last_idx)) st_n = par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (bit_end) st_n = ST_STOP;
            ST_STOP:  if (bit_end && stop_last) st_n = hold_full ? ST_START : ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shf[sel];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bidx      <= '0;
            hold_q    <= '0;
            shf       <= '0;
            hold_full <= 1'b0;
        end else begin
            if (load)      tcnt <= '0;
            else if (tick) tcnt <= tcnt + CNT_W'(1);

            if (st_n != st)   bidx <= '0;
            else if (bit_end) bidx <= bidx + 4'd1;

            if (load) begin
                shf       <= hold_q;
                hold_full <= 1'b0;
            end else if (wr && !hold_full) begin
                hold_q    <= wdata;
                hold_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              msb_first,
    input  logic              rd,
    input  logic              err_clr,
    output logic [WORD_W-1:0] rdata,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              done
);
    frame_st_t         st, st_n;
    logic [CNT_W-1:0]  tcnt;
    logic [3:0]        bidx, nbits, last_idx;
    logic [WORD_W-1:0] shr, aligned;
    logic              samp, stop_last, par_bad, stop_bad, exp_par;

    assign nbits     = frame_len(len_code);
    assign last_idx  = nbits - 4'd1;
    assign samp      = tick && (tcnt == ((st == ST_START) ? MID_TICK : LAST_TICK));
    assign stop_last = !stop2 || (bidx == 4'd1);
    assign aligned   = msb_first ? (shr & len_mask(nbits)) : (shr >> (4'(WORD_W) - nbits));
    assign exp_par   = (^aligned) ^ par_odd;
    assign done      = (st == ST_STOP) && samp && stop_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (tick && !rxd) st_n = ST_START;
            ST_START: if (samp) st_n = rxd ? ST_IDLE : ST_DATA;
            ST_DATA:  if (samp && (bidx == last_idx)) st_n = par_en ? ST_PAR : ST_STOP;
            ST_PAR:   if (samp) st_n = ST_STOP;
            ST_STOP:  if (samp && stop_last) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bidx     <= '0;
            shr      <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            rdata    <= '0;
            ready    <= 1'b0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            if (st_n != st) tcnt <= '0;
            else if (tick)  tcnt <= tcnt + CNT_W'(1);

            if (st_n != st) bidx <= '0;
            else if (samp)  bidx <= bidx + 4'd1;

            if (st == ST_START) begin
                shr      <= '0;
                par_bad  <= 1'b0;
                stop_bad <= 1'b0;
            end
            if ((st == ST_DATA) && samp)
                shr <= msb_first ? {shr[WORD_W-2:0], rxd} : {rxd, shr[WORD_W-1:1]};
            if ((st == ST_PAR) && samp)
                par_bad <= rxd ^ exp_par;
            if ((st == ST_STOP) && samp && !rxd)
                stop_bad <= 1'b1;

            if (done) begin
                rdata <= aligned;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end

            if (done && par_en && par_bad) perr <= 1'b1;
            else if (err_clr)              perr <= 1'b0;

            if (done && (stop_bad || !rxd)) ferr <= 1'b1;
            else if (err_clr)               ferr <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div_int,
    input  logic [3:0]        cfg_div_frac,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_msb_first,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              rxd,
    input  logic              rx_rd,
    input  logic              err_clr,
    output logic              txd,
    output logic [WORD_W-1:0] rx_data,
    output logic [STAT_W-1:0] status
);
    logic baud_tick, rx_done, tx_empty, rx_ready, rx_perr, rx_ferr;
    logic rxd_meta, rxd_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_meta <= 1'b1;
            rxd_sync <= 1'b1;
        end else begin
            rxd_meta <= rxd;
            rxd_sync <= rxd_meta;
        end
    end

    uart_baud #(.DIV_W(DIV_W)) i_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_int  (cfg_div_int),
        .div_frac (cfg_div_frac),
        .tick     (baud_tick)
    );

    uart_tx i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .len_code  (cfg_len),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .stop2     (cfg_stop2),
        .msb_first (cfg_msb_first),
        .wr        (tx_wr),
        .wdata     (tx_data),
        .txd       (txd),
        .buf_empty (tx_empty)
    );

    uart_rx i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rxd       (rxd_sync),
        .len_code  (cfg_len),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .stop2     (cfg_stop2),
        .msb_first (cfg_msb_first),
        .rd        (rx_rd),
        .err_clr   (err_clr),
        .rdata     (rx_data),
        .ready     (rx_ready),
        .perr      (rx_perr),
        .ferr      (rx_ferr),
        .done      (rx_done)
    );

    assign status = {rx_ferr, rx_perr, tx_empty, rx_ready};
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [DIV_W-1:0] div_int,
    input logic [3:0]       status,
    input logic             tx_wr,
    input logic             txd,
    input logic             rx_rd,
    input logic             err_clr,
    input logic             rx_done
);
    logic [DIV_W:0] gap;
    logic           seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= (DIV_W+1)'(1);
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + (DIV_W+1)'(1);
        end
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && seen |-> (gap == {1'b0, div_int}) || (gap == {1'b0, div_int} + (DIV_W+1)'(1)));

    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && status[1] |=> !status[1]);

    assert_empty_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !txd);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd && !rx_done |=> !status[0]);

    assert_delivery_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> status[0]);

    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] && !err_clr |=> status[2]);

    assert_ferr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] && !err_clr |=> status[3]);
endmodule

bind uart_xcvr uart_xcvr_chk #(.DIV_W(DIV_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .div_int (cfg_div_int),
    .status  (status),
    .tx_wr   (tx_wr),
    .txd     (txd),
    .rx_rd   (rx_rd),
    .err_clr (err_clr),
    .rx_done (rx_done)
);

// File: tb/test_uart_xcvr.sv
module test_uart_xcvr;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div_int = 12'd4;
    logic [3:0]       cfg_div_frac = 4'd0;
    logic [1:0]       cfg_len = 2'd2;
    logic             cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_msb_first = 1'b0;
    logic             tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0, rxd = 1'b1;
    logic [8:0]       tx_data = '0;
    logic             txd;
    logic [8:0]       rx_data;
    logic [3:0]       status;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    uart_xcvr #(.DIV_W(DIV_W)) i_uart_xcvr (
        .clk, .rst_n, .cfg_div_int, .cfg_div_frac, .cfg_len, .cfg_par_en, .cfg_par_odd,
        .cfg_stop2, .cfg_msb_first, .tx_wr, .tx_data, .rxd, .rx_rd, .err_clr,
        .txd, .rx_data, .status
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: tick schedule from the closed formula, line as a queue of bits.
    bit     line_q[$];
    longint edge_n, tick_n, next_t;
    int     ticks_in_bit;
    bit     m_full;
    logic [8:0] m_data;

    function automatic int nbits();
        return 6 + int'(cfg_len);
    endfunction

    function automatic bit par_of(input logic [8:0] d);
        bit p = cfg_par_odd;
        for (int k = 0; k < nbits(); k++) p ^= d[k];
        return p;
    endfunction

    task automatic push_frame(input logic [8:0] d);
        line_q.push_back(1'b0);
        for (int k = 0; k < nbits(); k++)
            line_q.push_back(cfg_msb_first ? d[nbits()-1-k] : d[k]);
        if (cfg_par_en) line_q.push_back(par_of(d));
        line_q.push_back(1'b1);
        if (cfg_stop2) line_q.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0; tick_n = 0; next_t = 0; ticks_in_bit = 0; m_full = 0;
            line_q.delete();
        end else begin
            bit is_tick, accept;
            accept = tx_wr && !m_full;
            is_tick = (edge_n == next_t);
            if (is_tick) begin
                tick_n++;
                next_t = tick_n * longint'(cfg_div_int) + (tick_n * longint'(cfg_div_frac)) / 16;
                if (line_q.size() != 0) begin
                    ticks_in_bit++;
                    if (ticks_in_bit == 16) begin
                        void'(line_q.pop_front());
                        ticks_in_bit = 0;
                    end
                end
                if (line_q.size() == 0 && m_full) begin
                    push_frame(m_data);
                    m_full = 0;
                    ticks_in_bit = 0;
                end
            end
            if (accept) begin
                m_full = 1;
                m_data = tx_data;
            end
            edge_n++;
        end
    end

    // Every-clock comparison of the line and the transmit-empty flag (R2 R3 R7).
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 R3 txd", int'(txd), line_q.size() != 0 ? int'(line_q[0]) : 1);
            check("R7 tx-empty", int'(status[1]), int'(!m_full));
        end
    end

    task automatic setup(input int div, input int frac, input int len, input bit pe,
                         input bit po, input bit s2, input bit msb);
        rst_n = 1'b0;
        cfg_div_int = DIV_W'(div); cfg_div_frac = 4'(frac); cfg_len = 2'(len);
        cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_msb_first = msb;
        tx_wr = 0; rx_rd = 0; err_clr = 0; rxd = 1;
        repeat (3) @(negedge clk);
        check("R1 reset txd", int'(txd), 1);
        check("R1 reset status", int'(status), 4'b0010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_write(input logic [8:0] d);
        tx_wr = 1; tx_data = d;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic wait_tx_idle();
        for (int t = 0; t < 20000 && (line_q.size() != 0 || m_full); t++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int t = 0; t < 20000 && !status[1]; t++) @(negedge clk);
    endtask

    task automatic drive_bit(input bit b, input bit disturb, input int p);
        for (int c = 0; c < p; c++) begin
            rxd = (disturb && (c < p/4 || c >= p - p/8)) ? ~b : b;
            @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [8:0] d, input bit bad_par, input bit bad_stop, input bit disturb);
        int p = 16 * int'(cfg_div_int) + int'(cfg_div_frac);
        drive_bit(1'b0, 1'b0, p);
        for (int k = 0; k < nbits(); k++)
            drive_bit(cfg_msb_first ? d[nbits()-1-k] : d[k], disturb, p);
        if (cfg_par_en) drive_bit(par_of(d) ^ bad_par, 1'b0, p);
        drive_bit(!bad_stop, 1'b0, p);
        if (cfg_stop2) drive_bit(1'b1, 1'b0, p);
        rxd = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic rx_expect(input string req, input logic [8:0] d, input bit pe, input bit fe);
        logic [8:0] mask = 9'h1FF >> (9 - nbits());
        check({req, " rx data"}, int'(rx_data), int'(d & mask));
        check("R10 ready set", int'(status[0]), 1);
        check("R6 R11 parity flag", int'(status[2]), int'(pe));
        check("R11 framing flag", int'(status[3]), int'(fe));
        rx_rd = 1; @(negedge clk); rx_rd = 0;
        check("R10 ready cleared by read", int'(status[0]), 0);
    endtask

    initial begin
        #(4 * 190000);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Phase 1: 8 bits, no parity, one stop, LSB first (R3 R4 R5 R7).
        setup(4, 0, 2, 0, 0, 0, 0);
        tx_write(9'h0A5);
        wait_empty();
        tx_write(9'h05A);
        tx_write(9'h0FF);   // R7: buffer full, this write must be ignored
        check("R7 full after ignored write", int'(status[1]), 0);
        wait_tx_idle();
        send_rx(9'h03C, 0, 0, 0);
        rx_expect("R4 R5", 9'h03C, 0, 0);

        // Phase 2: 9 bits, even parity, two stops, MSB first, fractional divisor (R2 R6 R8).
        setup(3, 5, 3, 1, 0, 1, 1);
        tx_write(9'h1A7);
        wait_empty();
        tx_write(9'h063);
        wait_tx_idle();
        send_rx(9'h155, 0, 0, 1);
        rx_expect("R8 R5", 9'h155, 0, 0);
        send_rx(9'h0F0, 1, 0, 0);
        rx_expect("R6", 9'h0F0, 1, 0);
        err_clr = 1; @(negedge clk); err_clr = 0;
        check("R11 parity flag cleared", int'(status[2]), 0);

        // Phase 3: 6 bits, odd parity, one stop, LSB first (R4 R6 R9 R11).
        setup(5, 15, 0, 1, 1, 0, 0);
        tx_write(9'h1EB);   // R4: upper bits beyond 6 are ignored
        wait_tx_idle();
        rxd = 0; repeat (4 * 5) @(negedge clk); rxd = 1;
        repeat (3 * (16 * 5 + 15)) @(negedge clk);
        check("R9 glitch gives no character", int'(status[0]), 0);
        send_rx(9'h02D, 0, 1, 0);
        rx_expect("R4", 9'h02D, 0, 1);
        send_rx(9'h012, 0, 0, 0);
        rx_expect("R11 sticky", 9'h012, 0, 1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        check("R11 framing flag cleared", int'(status[3]), 0);

        // Phase 4: 7 bits, MSB first, back-to-back characters (R3 R5 R7).
        setup(2, 8, 1, 0, 0, 0, 1);
        tx_write(9'h041);
        tx_write(9'h07E);   // R7 ignored: buffer still full
        wait_empty();
        tx_write(9'h013);
        wait_empty();
        tx_write(9'h06C);
        wait_tx_idle();
        send_rx(9'h05B, 0, 0, 1);
        rx_expect("R5 R8", 9'h05B, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule